// File: doc/BRIEF.md
# Timer Event Flag Register

This block holds the four event flags of a 16-bit timer/counter: the capture flag, two compare-match flags (channel A and channel B) and the overflow flag. The counter, the compare registers and the waveform mode come in from the timer. A flag is set only when the timer clock enable is high. It is cleared in two ways: software writes a one to the flag's bit over a simple write port, or the interrupt controller sends an acknowledge strobe for that flag's vector.

The rules for setting the flags depend on the waveform mode. In the modes that use the capture register as TOP, the capture flag follows TOP instead of the capture input. Compare flags are set one timer tick late. The overflow flag follows the full-range wrap in normal and clear-on-compare modes, and follows the TOP-to-BOTTOM wrap in every other mode. Each flag drives a level interrupt request, gated by its own enable.

Top module: `tmr_evt_flags`

## Requirements
- R1: After reset, every readback bit is 0 and all four interrupt requests are low.
- R2: In the readback, bit 5 is the capture flag, bit 4 is compare-A, bit 3 is compare-B and bit 2 is overflow. Bits 7:6 and 1:0 always read 0, even after ones are written to them.
- R3: In waveform modes other than 8, 10, 12 and 14, a clock with `tick` and `cap_evt` both high sets the capture flag, and the flag is visible after that edge.
- R4: In waveform modes 8, 10, 12 and 14, a clock with `tick` and `top_hit` both high sets the capture flag. In these modes `cap_evt` has no effect.
- R5: If a tick occurs while `count` equals `cmp_a` (or `cmp_b`), the matching compare flag is set on the next tick, not on the matching tick.
- R6: A `force_a` or `force_b` strobe never sets a compare flag.
- R7: In modes 0, 4 and 12, a tick with `count` at all ones sets the overflow flag. In these modes `top_hit` alone does not set it.
- R8: In all other modes, a tick with `top_hit` high sets the overflow flag. In these modes a count of all ones alone does not set it.
- R9: When `tick` is low, no event sets any flag.
- R10: A write with `wr_en` high clears each flag whose bit in `wr_data` is 1. Flags whose bit is 0 are left unchanged.
- R11: An acknowledge strobe (`ack_cap`, `ack_a`, `ack_b`, `ack_ovf`) clears its own flag.
- R12: If a set event and a clear (write-one or acknowledge) hit the same flag in the same clock, the flag ends up set.
- R13: Each interrupt request is high exactly while its flag and its enable are both high, and it stays high until the flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer clock enable; events are sampled only when this is high |
| count | input | 16 | Current counter value |
| cmp_a | input | 16 | Compare value, channel A |
| cmp_b | input | 16 | Compare value, channel B |
| cap_evt | input | 1 | Capture-pin event |
| top_hit | input | 1 | Counter is at TOP |
| wave_mode | input | 4 | Waveform generation mode |
| force_a | input | 1 | Forced-compare strobe, channel A |
| force_b | input | 1 | Forced-compare strobe, channel B |
| wr_en | input | 1 | Write strobe for the flag register |
| wr_data | input | 8 | Write data; a one clears the flag at that bit |
| ack_cap | input | 1 | Vector acknowledge, capture |
| ack_a | input | 1 | Vector acknowledge, compare A |
| ack_b | input | 1 | Vector acknowledge, compare B |
| ack_ovf | input | 1 | Vector acknowledge, overflow |
| en_cap | input | 1 | Interrupt enable, capture |
| en_a | input | 1 | Interrupt enable, compare A |
| en_b | input | 1 | Interrupt enable, compare B |
| en_ovf | input | 1 | Interrupt enable, overflow |
| flags | output | 8 | Flag register readback |
| irq_cap | output | 1 | Interrupt request, capture |
| irq_a | output | 1 | Interrupt request, compare A |
| irq_b | output | 1 | Interrupt request, compare B |
| irq_ovf | output | 1 | Interrupt request, overflow |

## Verification
The hardest case to reach from the ports is a set colliding with a clear on the same edge. The flag must already be set, and then a ticked event and a clear must arrive in one cycle. The stimulus first sets the capture flag, then drives a capture event together with its acknowledge, and drives the same kind of collision between a compare-B match and a write-one. The one-tick compare delay is exposed by placing an idle cycle with `tick` low between the matching tick and the following tick. This shows that the flag waits for the next timer tick and not for the next system clock.

// File: rtl/tmr_evt_flags.sv
module tmr_evt_flags #(
  parameter int CNT_W    = 16,
  parameter int MODE_W   = 4,
  parameter int REG_W    = 8,
  parameter int CAP_BIT  = 5,
  parameter int CMPA_BIT = 4,
  parameter int CMPB_BIT = 3,
  parameter int OVF_BIT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  cmp_a,
  input  logic [CNT_W-1:0]  cmp_b,
  input  logic              cap_evt,
  input  logic              top_hit,
  input  logic [MODE_W-1:0] wave_mode,
  input  logic              force_a,
  input  logic              force_b,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              ack_cap,
  input  logic              ack_a,
  input  logic              ack_b,
  input  logic              ack_ovf,
  input  logic              en_cap,
  input  logic              en_a,
  input  logic              en_b,
  input  logic              en_ovf,
  output logic [REG_W-1:0]  flags,
  output logic              irq_cap,
  output logic              irq_a,
  output logic              irq_b,
  output logic              irq_ovf
);

  localparam int NF = 4;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // flag index: 3 capture, 2 compare A, 1 compare B, 0 overflow
  logic [NF-1:0] flg, set_v, clr_v, ack_v, en_v;
  logic          pend_a, pend_b;
  logic          cap_is_top, wrap_full;
  logic          unused_force;

  // compare strobes are deliberately kept out of the flag path
  assign unused_force = force_a ^ force_b;

  assign cap_is_top = (wave_mode == MODE_W'(8))  || (wave_mode == MODE_W'(10)) ||
                      (wave_mode == MODE_W'(12)) || (wave_mode == MODE_W'(14));
  assign wrap_full  = (wave_mode == MODE_W'(0))  || (wave_mode == MODE_W'(4))  ||
                      (wave_mode == MODE_W'(12));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_a <= 1'b0;
      pend_b <= 1'b0;
    end else if (tick) begin
      pend_a <= (count == cmp_a);
      pend_b <= (count == cmp_b);
    end
  end

  assign set_v[3] = tick && (cap_is_top ? top_hit : cap_evt);
  assign set_v[2] = tick && pend_a;
  assign set_v[1] = tick && pend_b;
  assign set_v[0] = tick && (wrap_full ? (count == CNT_MAX) : top_hit);

  assign ack_v = {ack_cap, ack_a, ack_b, ack_ovf};
  assign en_v  = {en_cap, en_a, en_b, en_ovf};

  for (genvar i = 0; i < NF; i++) begin : g_flag
    localparam int P = (i == 3) ? CAP_BIT : (i == 2) ? CMPA_BIT :
                       (i == 1) ? CMPB_BIT : OVF_BIT;
    assign clr_v[i] = (wr_en && wr_data[P]) || ack_v[i];
    always_ff @(posedge clk) begin
      if (!rst_n) flg[i] <= 1'b0;
      else        flg[i] <= set_v[i] || (flg[i] && !clr_v[i]);
    end
  end

  always_comb begin
    flags           = '0;
    flags[CAP_BIT]  = flg[3];
    flags[CMPA_BIT] = flg[2];
    flags[CMPB_BIT] = flg[1];
    flags[OVF_BIT]  = flg[0];
  end

  assign {irq_cap, irq_a, irq_b, irq_ovf} = flg & en_v;

endmodule

// File: rtl/tmr_evt_flags_chk.sv
module tmr_evt_flags_chk #(
  parameter int MODE_W = 4,
  parameter int REG_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              cap_evt,
  input logic [MODE_W-1:0] wave_mode,
  input logic              wr_en,
  input logic [REG_W-1:0]  wr_data,
  input logic              ack_cap,
  input logic              ack_a,
  input logic [REG_W-1:0]  flags,
  input logic              irq_a
);

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flags[REG_W-1:6] == '0 && flags[1:0] == 2'b00);

  p_set_needs_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[4]) |-> $past(tick));

  p_cap_clear_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[5]) |-> $past((wr_en && wr_data[5]) || ack_cap));

  p_a_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[4] && !ack_a && !(wr_en && wr_data[4])) |=> flags[4]);

  p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cap_evt && wave_mode == '0 && (ack_cap || (wr_en && wr_data[5]))) |=> flags[5]);

  p_irq_needs_flag_r13: assert property (@(posedge clk) disable iff (!rst_n)
    irq_a |-> flags[4]);

endmodule

bind tmr_evt_flags tmr_evt_flags_chk #(.MODE_W(MODE_W), .REG_W(REG_W)) u_chk (.*);

// File: tb/tmr_evt_flags_test.sv
module tmr_evt_flags_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 0, cap_evt = 0, top_hit = 0, force_a = 0, force_b = 0;
  logic [15:0] count = 0, cmp_a = 16'h0010, cmp_b = 16'h0020;
  logic [3:0]  wave_mode = 0;
  logic        wr_en = 0;
  logic [7:0]  wr_data = 0;
  logic        ack_cap = 0, ack_a = 0, ack_b = 0, ack_ovf = 0;
  logic        en_cap = 1, en_a = 1, en_b = 1, en_ovf = 1;
  logic [7:0]  flags;
  logic        irq_cap, irq_a, irq_b, irq_ovf;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct { logic [7:0] f; logic [3:0] irq; string tag; } item_t;
  item_t q[$];

  // bench model: index 3 cap, 2 A, 1 B, 0 ovf
  logic [3:0] m = 0;
  logic       m_pa = 0, m_pb = 0;

  always #2 clk = ~clk;

  tmr_evt_flags uut (.*);

  task automatic step(input logic tk, input logic [15:0] cnt, input logic cev,
                      input logic th, input logic fa, input logic fb,
                      input logic we, input logic [7:0] wd, input logic [3:0] ack,
                      input string tag);
    logic [3:0] s, c;
    logic       ctop, full;
    item_t it;
    tick = tk; count = cnt; cap_evt = cev; top_hit = th; force_a = fa; force_b = fb;
    wr_en = we; wr_data = wd; {ack_cap, ack_a, ack_b, ack_ovf} = ack;
    ctop = wave_mode inside {4'd8, 4'd10, 4'd12, 4'd14};
    full = wave_mode inside {4'd0, 4'd4, 4'd12};
    s[3] = tk && (ctop ? th : cev);
    s[2] = tk && m_pa;
    s[1] = tk && m_pb;
    s[0] = tk && (full ? (cnt == 16'hFFFF) : th);
    c = ({4{we}} & {wd[5], wd[4], wd[3], wd[2]}) | ack;
    if (!rst_n) begin
      m = 0; m_pa = 0; m_pb = 0;
    end else begin
      if (tk) begin m_pa = (cnt == cmp_a); m_pb = (cnt == cmp_b); end
      m = s | (m & ~c);
    end
    it.f = {2'b00, m, 2'b00};
    it.irq = m & {en_cap, en_a, en_b, en_ovf};
    it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step(0, 16'h0001, 0, 0, 0, 0, 0, 8'h00, 4'h0, tag);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (flags !== it.f || {irq_cap, irq_a, irq_b, irq_ovf} !== it.irq) begin
          failures++;
          $display("FAIL %s flags=%h irq=%b expected flags=%h irq=%b",
                   it.tag, flags, {irq_cap, irq_a, irq_b, irq_ovf}, it.f, it.irq);
        end
      end
    end
  end

  initial begin : watchdog
    #800000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    idle("R1 reset");
    idle("R1 reset");
    rst_n = 1'b1;
    idle("R1 after reset");
    // capture input in mode 0
    step(1, 16'h0003, 1, 0, 0, 0, 0, 8'h00, 4'h0, "R3 capture event");
    step(0, 16'h0003, 0, 0, 0, 0, 1, 8'h00, 4'h0, "R10 write zero keeps");
    step(0, 16'h0003, 0, 0, 0, 0, 1, 8'h20, 4'h0, "R10 write one clears");
    step(0, 16'h0003, 1, 1, 0, 0, 0, 8'h00, 4'h0, "R9 capture without tick");
    step(0, 16'hFFFF, 0, 1, 0, 0, 0, 8'h00, 4'h0, "R9 wrap without tick");
    // compare delay
    step(1, 16'h0010, 0, 0, 0, 0, 0, 8'h00, 4'h0, "R5 match tick no flag yet");
    idle("R5 no tick between");
    step(1, 16'h0011, 0, 0, 0, 0, 0, 8'h00, 4'h0, "R5 flag A on next tick");
    step(1, 16'h0020, 0, 0, 0, 0, 0, 8'h00, 4'h0, "R5 match B");
    step(1, 16'h0021, 0, 0, 0, 0, 0, 8'h00, 4'h0, "R5 flag B");
    step(0, 16'h0021, 0, 0, 0, 0, 1, 8'h18, 4'h0, "R10 clear A and B");
    // forced compare
    step(1, 16'h0030, 0, 0, 1, 1, 0, 8'h00, 4'h0, "R6 force strobes");
    step(1, 16'h0031, 0, 0, 1, 1, 0, 8'h00, 4'h0, "R6 force no flag");
    // overflow, normal mode
    step(1, 16'h0005, 0, 1, 0, 0, 0, 8'h00, 4'h0, "R7 top_hit ignored mode0");
    step(1, 16'hFFFF, 0, 0, 0, 0, 0, 8'h00, 4'h0, "R7 overflow mode0");
    step(0, 16'h0000, 0, 0, 0, 0, 0, 8'h00, 4'b0001, "R11 ack overflow");
    // acknowledge for compare A
    step(1, 16'h0010, 0, 0, 0, 0, 0, 8'h00, 4'h0, "R5 match A again");
    step(1, 16'h0011, 0, 0, 0, 0, 0, 8'h00, 4'h0, "R5 flag A again");
    step(0, 16'h0011, 0, 0, 0, 0, 0, 8'h00, 4'b0100, "R11 ack A");
    // mode 4: clear-on-compare
    wave_mode = 4'd4;
    step(1, 16'hFFFF, 0, 1, 0, 0, 0, 8'h00, 4'h0, "R7 overflow mode4");
    step(0, 16'h0000, 0, 0, 0, 0, 1, 8'h04, 4'h0, "R10 clear ovf");
    // mode 8: capture register as TOP
    wave_mode = 4'd8;
    step(1, 16'h0040, 1, 0, 0, 0, 0, 8'h00, 4'h0, "R4 capture input ignored");
    step(1, 16'hFFFF, 0, 0, 0, 0, 0, 8'h00, 4'h0, "R8 full wrap ignored mode8");
    step(1, 16'h0100, 0, 1, 0, 0, 0, 8'h00, 4'h0, "R4 R8 top sets cap and ovf");
    step(0, 16'h0000, 0, 0, 0, 0, 0, 8'h00, 4'b1001, "R11 ack cap and ovf");
    // mode 1: other PWM, capture input used
    wave_mode = 4'd1;
    step(1, 16'h0080, 1, 0, 0, 0, 0, 8'h00, 4'h0, "R3 capture mode1");
    step(1, 16'h00FF, 0, 1, 0, 0, 0, 8'h00, 4'h0, "R8 top sets ovf mode1");
    step(0, 16'h0000, 0, 0, 0, 0, 1, 8'hFF, 4'h0, "R2 write all ones");
    // set wins over clear
    wave_mode = 4'd0;
    step(1, 16'h0001, 1, 0, 0, 0, 0, 8'h00, 4'h0, "R3 set cap");
    step(1, 16'h0020, 1, 0, 0, 0, 0, 8'h00, 4'b1000, "R12 ack with capture");
    step(1, 16'h0021, 0, 0, 0, 0, 1, 8'h08, 4'h0, "R12 write-one with B set");
    // interrupt masking
    en_a = 0; en_b = 0;
    step(1, 16'h0010, 0, 0, 0, 0, 0, 8'h00, 4'h0, "R13 masked");
    step(1, 16'h0011, 0, 0, 0, 0, 0, 8'h00, 4'h0, "R13 A set masked");
    en_a = 1;
    idle("R13 enable A");
    idle("R13 level held");
    en_b = 1;
    step(0, 16'h0000, 0, 0, 0, 0, 1, 8'h3C, 4'h0, "R10 R13 clear all");
    rst_n = 1'b0;
    idle("R1 reset again");
    rst_n = 1'b1;
    idle("R1 idle");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule